// File: doc/BRIEF.md
# Boot firmware destination router

This block decides where host accesses to the boot firmware window are sent. Three downstream ports can take them: a serial flash port, a legacy low-pin-count port and a bridge port. A 2-bit destination field selects the port. At power-up the field is loaded from two strap pins. Each strap is sampled on the rising edge of its own power-good signal. Software can later rewrite the field through a small register port, until it sets a set-only lock bit.

The routing decision is registered. A host request is accepted while `req_ready` is high. One clock later, the block either raises exactly one destination request or pulses `no_claim`. A raised destination request is held until that port acknowledges it, and no new request is accepted in the meantime.

Two cases override the destination field. In bridge mode, every access inside the top 16 MB window is sent to the bridge port, and the per-port qualifier inputs are ignored. Requests from the management agent and from the integrated network requester always go to the serial flash port, whatever the field holds.

Top module: `bootdst_router`

## Requirements
- R1: The destination field encodes the target as follows: 00 and 01 select the serial flash port, 10 selects the bridge port and 11 selects the low-pin-count port. A qualified host request (`req_src`=00) inside the window is routed to the encoded port.
- R2: On the first clock where `pgood_main` is seen high after being low, the upper destination bit takes the value of `strap_hi`. While `pgood_main` stays high, later changes on `strap_hi` have no effect.
- R3: On the first clock where `pgood_aux` is seen high after being low, the lower destination bit takes the value of `strap_lo`. This happens independently of `pgood_main`.
- R4: A register write loads `reg_wdata[2:1]` into the destination field only while the lock bit is clear. Once the lock is set, the field read back is unchanged by any write.
- R5: The lock bit is `reg_wdata[0]` and can only be set. Writing 0 does not clear it; only reset clears it.
- R6: In bridge mode, every request with address FF00_0000h to FFFF_FFFFh goes to the bridge port, even when both qualifier inputs are low.
- R7: In serial flash mode or low-pin-count mode, a window request is routed only if that port's qualifier input (`flash_qual` or `lpc_qual`) is high. Otherwise `no_claim` pulses.
- R8: A request with `req_src` = 01 (management agent) or 10 (integrated network) inside the window goes to the serial flash port when `flash_qual` is high, whatever the destination field holds.
- R9: A request whose address lies outside the window is not claimed by any port, and `no_claim` pulses for one cycle.
- R10: A destination request rises on the clock edge that accepts the host request. It stays high, with `req_ready` low, until that port's acknowledge is seen on a clock edge, and it then drops on that edge.
- R11: `reg_rdata` returns the lock in bit 0 and the destination field in bits 2:1. All other bits read as zero.
- R12: At most one of `flash_req`, `lpc_req`, `bridge_req` and `no_claim` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_hi | input | 1 | Strap for the upper destination bit |
| pgood_main | input | 1 | Main power-good; its rising edge captures `strap_hi` |
| strap_lo | input | 1 | Strap for the lower destination bit |
| pgood_aux | input | 1 | Second power-good; its rising edge captures `strap_lo` |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Write data: bit 0 is the lock, bits 2:1 are the destination |
| reg_rdata | output | REG_W | Read data: current lock and destination |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | High when no routed request is pending |
| req_addr | input | ADDR_W | Host memory address |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_src | input | 2 | Requester: 00 host, 01 management agent, 10 network, 11 other |
| flash_qual | input | 1 | Range qualifier for the serial flash port |
| lpc_qual | input | 1 | Range qualifier for the low-pin-count port |
| flash_req | output | 1 | Request to the serial flash port |
| flash_ack | input | 1 | Acknowledge from the serial flash port |
| lpc_req | output | 1 | Request to the low-pin-count port |
| lpc_ack | input | 1 | Acknowledge from the low-pin-count port |
| bridge_req | output | 1 | Request to the bridge port |
| bridge_ack | input | 1 | Acknowledge from the bridge port |
| out_addr | output | ADDR_W | Address of the routed request |
| out_write | output | 1 | Direction of the routed request |
| no_claim | output | 1 | One-cycle pulse when a request is not claimed |

## Verification
The bench drives each host request before a rising edge. It samples the result at the following falling edge, because either the port request or the `no_claim` pulse is registered on the same edge that accepts the request. A strap capture or register write is visible in `reg_rdata` at the falling edge after the edge that saw it. The monitor holds each port request for three falling edges before it raises the acknowledge. It then expects the request to be low, and `req_ready` high again, one edge later. Configuration changes wait until the scoreboard queue has drained, so each expected item is tied to the mode that was in force when its request was accepted.

// File: rtl/bootdst_pkg.sv
package bootdst_pkg;
    typedef enum logic [1:0] {
        RT_NONE   = 2'd0,
        RT_FLASH  = 2'd1,
        RT_LPC    = 2'd2,
        RT_BRIDGE = 2'd3
    } route_e;

    localparam logic [1:0] SRC_HOST  = 2'b00;
    localparam logic [1:0] SRC_MGMT  = 2'b01;
    localparam logic [1:0] SRC_NET   = 2'b10;
    localparam logic [1:0] SRC_OTHER = 2'b11;

    localparam logic [1:0] DST_BRIDGE = 2'b10;
    localparam logic [1:0] DST_LPC    = 2'b11;
endpackage

// File: rtl/bootdst_cfg.sv
module bootdst_cfg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_hi,
    input  logic             pgood_main,
    input  logic             strap_lo,
    input  logic             pgood_aux,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [1:0]       dest,
    output logic             lock,
    output logic [REG_W-1:0] reg_rdata
);
    localparam int PAD_W = REG_W - 3;

    typedef struct packed {
        logic [1:0] dest;
        logic       lock;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic pg_main_q, pg_aux_q;
    logic main_rise, aux_rise;

    // power-good history is kept running through reset so an edge is seen only once
    always_ff @(posedge clk) begin
        pg_main_q <= pgood_main;
        pg_aux_q  <= pgood_aux;
    end

    assign main_rise = pgood_main & ~pg_main_q;
    assign aux_rise  = pgood_aux & ~pg_aux_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            if (!cfg_q.lock) begin
                cfg_d.dest = reg_wdata[2:1];
            end
            cfg_d.lock = cfg_q.lock | reg_wdata[0];
        end
        if (main_rise) begin
            cfg_d.dest[1] = strap_hi;
        end
        if (aux_rise) begin
            cfg_d.dest[0] = strap_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dest      = cfg_q.dest;
    assign lock      = cfg_q.lock;
    assign reg_rdata = {{PAD_W{1'b0}}, cfg_q.dest, cfg_q.lock};
endmodule

// File: rtl/bootdst_decode.sv
module bootdst_decode
    import bootdst_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 8
) (
    input  logic [1:0]        dest,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        src,
    input  logic              flash_qual,
    input  logic              lpc_qual,
    output route_e            route
);
    logic in_win;
    logic priv;

    assign in_win = &addr[ADDR_W-1 -: WIN_BITS];
    assign priv   = (src == SRC_MGMT) || (src == SRC_NET);

    always_comb begin
        route = RT_NONE;
        if (in_win) begin
            if (priv) begin
                route = flash_qual ? RT_FLASH : RT_NONE;
            end else begin
                unique case (dest)
                    DST_BRIDGE: route = RT_BRIDGE;
                    DST_LPC:    route = lpc_qual ? RT_LPC : RT_NONE;
                    default:    route = flash_qual ? RT_FLASH : RT_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/bootdst_router.sv
module bootdst_router
    import bootdst_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 8,
    parameter int REG_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hi,
    input  logic              pgood_main,
    input  logic              strap_lo,
    input  logic              pgood_aux,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_src,
    input  logic              flash_qual,
    input  logic              lpc_qual,
    output logic              flash_req,
    input  logic              flash_ack,
    output logic              lpc_req,
    input  logic              lpc_ack,
    output logic              bridge_req,
    input  logic              bridge_ack,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    output logic              no_claim
);
    typedef struct packed {
        route_e            route;
        logic              noclaim;
        logic [ADDR_W-1:0] addr;
        logic              write;
    } rt_t;

    rt_t    st_d, st_q;
    logic [1:0] dest;
    logic   lock;
    route_e dec_route;
    logic   done;

    bootdst_cfg #(.REG_W(REG_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_hi   (strap_hi),
        .pgood_main (pgood_main),
        .strap_lo   (strap_lo),
        .pgood_aux  (pgood_aux),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .dest       (dest),
        .lock       (lock),
        .reg_rdata  (reg_rdata)
    );

    bootdst_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
        .dest       (dest),
        .addr       (req_addr),
        .src        (req_src),
        .flash_qual (flash_qual),
        .lpc_qual   (lpc_qual),
        .route      (dec_route)
    );

    assign req_ready = (st_q.route == RT_NONE);

    always_comb begin
        unique case (st_q.route)
            RT_FLASH:  done = flash_ack;
            RT_LPC:    done = lpc_ack;
            RT_BRIDGE: done = bridge_ack;
            default:   done = 1'b0;
        endcase
    end

    always_comb begin
        st_d         = st_q;
        st_d.noclaim = 1'b0;
        if (done) begin
            st_d.route = RT_NONE;
        end
        if (req_valid && req_ready) begin
            if (dec_route == RT_NONE) begin
                st_d.noclaim = 1'b1;
            end else begin
                st_d.route = dec_route;
                st_d.addr  = req_addr;
                st_d.write = req_write;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.route <= RT_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign flash_req  = (st_q.route == RT_FLASH);
    assign lpc_req    = (st_q.route == RT_LPC);
    assign bridge_req = (st_q.route == RT_BRIDGE);
    assign out_addr   = st_q.addr;
    assign out_write  = st_q.write;
    assign no_claim   = st_q.noclaim;
endmodule

// File: rtl/bootdst_router_chk.sv
module bootdst_router_chk #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 8,
    parameter int REG_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pgood_main,
    input logic              pgood_aux,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_src,
    input logic              flash_qual,
    input logic              flash_req,
    input logic              flash_ack,
    input logic              lpc_req,
    input logic              lpc_ack,
    input logic              bridge_req,
    input logic              bridge_ack,
    input logic              no_claim
);
    logic in_win, take, priv;
    assign in_win = &req_addr[ADDR_W-1 -: WIN_BITS];
    assign take   = req_valid && req_ready;
    assign priv   = (req_src == 2'b01) || (req_src == 2'b10);

    // R12
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flash_req, lpc_req, bridge_req, no_claim}));

    // R10
    flash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && !flash_ack) |=> flash_req);

    // R10
    lpc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpc_req && !lpc_ack) |=> lpc_req);

    // R10
    bridge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_req && !bridge_ack) |=> bridge_req);

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[0] |=> reg_rdata[0]);

    // R4
    locked_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && $stable(pgood_main) && $stable(pgood_aux)) |=> $stable(reg_rdata[2:1]));

    // R6
    bridge_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_win && !priv && reg_rdata[2:1] == 2'b10) |=> bridge_req);

    // R8
    priv_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_win && priv && flash_qual) |=> flash_req);

    // R9
    outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_win) |=> no_claim);
endmodule

bind bootdst_router bootdst_router_chk #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .REG_W(REG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pgood_main (pgood_main),
    .pgood_aux  (pgood_aux),
    .reg_rdata  (reg_rdata),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_src    (req_src),
    .flash_qual (flash_qual),
    .flash_req  (flash_req),
    .flash_ack  (flash_ack),
    .lpc_req    (lpc_req),
    .lpc_ack    (lpc_ack),
    .bridge_req (bridge_req),
    .bridge_ack (bridge_ack),
    .no_claim   (no_claim)
);

// File: tb/bootdst_router_bench.sv
module bootdst_router_bench;
    localparam int AW = 32;
    localparam int RW = 8;
    // expected route codes: 0 none, 1 flash, 2 lpc, 3 bridge
    localparam int E_NONE = 0, E_FLASH = 1, E_LPC = 2, E_BRIDGE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_hi = 1'b0, pgood_main = 1'b0, strap_lo = 1'b0, pgood_aux = 1'b0;
    logic reg_wr = 1'b0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_src = 2'b00;
    logic flash_qual = 1'b0, lpc_qual = 1'b0;
    logic flash_req, lpc_req, bridge_req, no_claim, out_write;
    logic flash_ack = 1'b0, lpc_ack = 1'b0, bridge_ack = 1'b0;
    logic [AW-1:0] out_addr;

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    typedef struct { int route; logic [AW-1:0] addr; string tag; } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    bootdst_router u_bootdst_router (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [RW-1:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send(input logic [AW-1:0] a, input logic [1:0] s, input int exp, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_src = s; req_write = a[0];
        sb.push_back('{exp, a, tag});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((sb.size() != 0 || !req_ready) && n < 50) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    // monitor: pops one expected item per result and acknowledges after three edges
    int hold = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                int cur;
                exp_t e;
                cur = flash_req ? E_FLASH : lpc_req ? E_LPC : bridge_req ? E_BRIDGE : E_NONE;
                if (no_claim) begin
                    if (sb.size() == 0) chk(1'b0, "R12 unexpected no_claim", 1, 0);
                    else begin
                        e = sb.pop_front();
                        chk(e.route == E_NONE, e.tag, E_NONE, e.route);
                    end
                end
                if (cur != E_NONE) begin
                    if (hold == 0) begin
                        if (sb.size() == 0) chk(1'b0, "R12 unexpected request", cur, 0);
                        else begin
                            e = sb.pop_front();
                            chk(e.route == cur, e.tag, cur, e.route);
                            chk(out_addr == e.addr, "R10 out_addr", int'(out_addr), int'(e.addr));
                        end
                        chk(!req_ready, "R10 ready low while pending", int'(req_ready), 0);
                    end
                    if (hold == 2) begin
                        flash_ack  = (cur == E_FLASH);
                        lpc_ack    = (cur == E_LPC);
                        bridge_ack = (cur == E_BRIDGE);
                    end
                    hold++;
                end else if (hold != 0) begin
                    chk(hold == 3, "R10 held until ack", hold, 3);
                    chk(req_ready, "R10 ready after ack", int'(req_ready), 1);
                    flash_ack = 1'b0; lpc_ack = 1'b0; bridge_ack = 1'b0;
                    hold = 0;
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_rdata == 8'h00, "R11 reset readback", reg_rdata, 0);
        chk(!flash_req && !lpc_req && !bridge_req && !no_claim, "R12 reset outputs idle", 0, 0);
        chk(req_ready, "R10 reset ready", int'(req_ready), 1);

        // straps
        strap_hi = 1'b1; pgood_main = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(reg_rdata == 8'h04, "R2 upper strap captured", reg_rdata, 8'h04);
        strap_lo = 1'b1; pgood_aux = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(reg_rdata == 8'h06, "R3 lower strap captured", reg_rdata, 8'h06);
        strap_hi = 1'b0; strap_lo = 1'b0;
        repeat (2) @(negedge clk);
        chk(reg_rdata == 8'h06, "R2 strap change after edge ignored", reg_rdata, 8'h06);

        // low-pin-count mode (11)
        lpc_qual = 1'b1; flash_qual = 1'b1;
        send(32'hFF80_0010, 2'b00, E_LPC, "R1 lpc mode routes lpc");
        drain();
        lpc_qual = 1'b0;
        send(32'hFFF0_0000, 2'b00, E_NONE, "R7 lpc qualifier low");
        send(32'hFF00_0001, 2'b10, E_FLASH, "R8 network requester to flash");
        drain();

        // flash mode 01 with reserved bits set in write data
        reg_write(8'hF2);
        @(negedge clk);
        chk(reg_rdata == 8'h02, "R11 reserved bits read zero", reg_rdata, 8'h02);
        send(32'hFFFF_FFFC, 2'b00, E_FLASH, "R1 flash mode 01");
        send(32'hFEFF_FFFF, 2'b00, E_NONE, "R9 below window");
        drain();
        flash_qual = 1'b0;
        send(32'hFF12_3456, 2'b00, E_NONE, "R7 flash qualifier low");
        drain();
        flash_qual = 1'b1;

        // flash mode 00
        reg_write(8'h00);
        @(negedge clk);
        chk(reg_rdata == 8'h00, "R4 unlocked write", reg_rdata, 0);
        send(32'hFF00_0000, 2'b00, E_FLASH, "R1 flash mode 00");
        drain();

        // bridge mode and lock
        reg_write(8'h05);
        @(negedge clk);
        chk(reg_rdata == 8'h05, "R5 lock set with bridge", reg_rdata, 8'h05);
        flash_qual = 1'b0; lpc_qual = 1'b0;
        send(32'hFF40_0000, 2'b00, E_BRIDGE, "R6 bridge ignores qualifiers");
        send(32'hFFFF_FFFF, 2'b11, E_BRIDGE, "R6 bridge top address");
        send(32'h0000_1000, 2'b00, E_NONE, "R9 outside window in bridge mode");
        drain();
        flash_qual = 1'b1;
        send(32'hFF00_0100, 2'b01, E_FLASH, "R8 management requester to flash");
        drain();
        reg_write(8'h06);
        @(negedge clk);
        chk(reg_rdata == 8'h05, "R4 write ignored when locked", reg_rdata, 8'h05);
        chk(reg_rdata[0] == 1'b1, "R5 lock not cleared by zero", int'(reg_rdata[0]), 1);

        drain();
        chk(sb.size() == 0, "R10 all results produced", sb.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule